// File: doc/BRIEF.md
# Two-Wire Serial ROM Snapshot Sequencer

This block copies the full contents of a 128-word by 8-bit two-wire serial memory into an on-chip register array. A single-cycle start pulse launches the run. The block drives the clock line directly. It handles the data line open-drain style: it either pulls the line low or releases it, and it reads the line back through a two-flop synchronizer. Every clock or data line change, and every sample, is followed by a hold of `HOLD_CYC` system clocks, so one parameter sets the bus rate.

Each word is fetched by its own short transaction. The transaction is a start condition, then an address byte (the word index shifted up one place with a 1 in the lowest bit, most significant bit first), then an acknowledge check. If the memory acknowledges, eight data bits follow, then a trailing acknowledge cycle whose result is discarded. If the memory does not acknowledge, the block skips the data and stores 0xFF for that word. No stop condition is ever issued: the next word begins directly with a new start condition.

When all words are stored, `done_o` rises and stays high until the next start. The captured array can then be read through a plain combinational read port. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure: the read port is a random-access lookup that is valid in the same cycle.

Top module: `rom_snapshot`

## Requirements
- R1: During and right after reset, `busy_o` and `done_o` are 0, `scl_o` is 1 and `sda_oe_o` is 0 (data released, so the line reads high).
- R2: A `start_i` pulse while idle sets `busy_o` on the next clock edge and clears `done_o`.
- R3: Each word begins with exactly one start condition: data falls while the clock is high. While busy, data never rises while the clock is high (no stop condition), so a full run shows 128 start conditions and zero stop conditions.
- R4: Address bytes equal `{word, 1'b1}`, are shifted out most significant bit first and are sampled on clock rising edges, and the words come in ascending order from 0 to 127.
- R5: For a word whose address is acknowledged (data sampled 0 during the ninth clock), the stored byte equals the eight bits the memory presented, with the most significant bit first.
- R6: For a word whose address is not acknowledged (data sampled 1), the stored byte is 0xFF.
- R7: Two consecutive changes of `scl_o` or `sda_oe_o` are at least `HOLD_CYC` system clocks apart.
- R8: After the 128th word is stored, `busy_o` falls and `done_o` rises in the same cycle. A `start_i` pulse while busy is ignored and does not restart the word sequence.
- R9: `rd_data_o` shows the stored byte at `rd_addr_i` in the same cycle, and a new run overwrites every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to begin a full read |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | High after a completed run until the next start |
| scl_o | output | 1 | Serial clock line level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Sampled level of the data line |
| rd_addr_i | input | 7 | Word index for the read port |
| rd_data_o | output | 8 | Stored byte at `rd_addr_i` |

## Verification
The bench connects a behavioral memory model to the bus. The model decodes start conditions and address bytes and answers with a byte computed from the word index. It refuses to acknowledge a chosen set of words that includes the first and the last. The first run mixes acknowledged and refused words, which tells the 0xFF substitution apart from real data and exposes off-by-one faults at both ends of the word range. The second run uses different contents and refuses a different word, which shows that every word is overwritten and that the first run's refused words now hold real data. Line-change spacing, the count of start and stop conditions, and the address order are observed on the bus pins throughout both runs.

// File: rtl/rsnap_pkg.sv
package rsnap_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_INIT,
    PH_START,
    PH_ADDR,
    PH_AACK,
    PH_DATA,
    PH_DACK
  } phase_t;
endpackage

// File: rtl/rsnap_sync.sv
module rsnap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsnap_pacer.sv
module rsnap_pacer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic ready_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               cnt_q <= '0;
    else if (go_i)            cnt_q <= CW'(HOLD_CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;

  assign ready_o = (cnt_q == '0);

  // R7
  hold_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (HOLD_CYC == 1) || !ready_o);
endmodule

// File: rtl/rsnap_store.sv
module rsnap_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we_i) mem[wa_i] <= wd_i;

  assign rd_o = mem[ra_i];

  // R9
  wr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/rom_snapshot.sv
module rom_snapshot
  import rsnap_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              scl_o,
  output logic              sda_oe_o,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int WORDS   = 1 << ADDR_W;
  localparam int ABYTE_W = ADDR_W + 1;
  localparam int BIT_W   = $clog2((ABYTE_W > DATA_W) ? ABYTE_W : DATA_W);
  localparam int GW      = $clog2(HOLD_CYC + 1);

  phase_t              phase_q;
  logic [2:0]          sub_q;
  logic [BIT_W-1:0]    bit_q;
  logic [ADDR_W-1:0]   word_q;
  logic [DATA_W-1:0]   shreg_q;
  logic                ack_q;
  logic                busy_q, done_q, scl_q, oe_q;
  logic                sda_s, ready, fire;
  logic [ABYTE_W-1:0]  addr_byte;
  logic                last_word;
  logic                we;
  logic [DATA_W-1:0]   wd;

  rsnap_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
  );

  rsnap_pacer #(.HOLD_CYC(HOLD_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .go_i(fire), .ready_o(ready)
  );

  assign fire      = busy_q && ready;
  assign addr_byte = {word_q, 1'b1};
  assign last_word = (word_q == ADDR_W'(WORDS - 1));

  assign we = fire && (sub_q == 3'd4) &&
              ((phase_q == PH_DACK) || (phase_q == PH_AACK && ack_q));
  assign wd = (phase_q == PH_AACK) ? {DATA_W{1'b1}} : shreg_q;

  rsnap_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(we), .wa_i(word_q), .wd_i(wd),
    .ra_i(rd_addr_i), .rd_o(rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      shreg_q <= '0;
      ack_q   <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      scl_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      word_q  <= '0;
      phase_q <= PH_INIT;
      sub_q   <= '0;
    end else if (fire) begin
      unique case (phase_q)
        PH_INIT: begin
          scl_q   <= 1'b1;
          oe_q    <= 1'b0;
          phase_q <= PH_START;
          sub_q   <= '0;
        end
        PH_START: begin
          case (sub_q)
            3'd0:    oe_q  <= 1'b0;
            3'd1:    scl_q <= 1'b1;
            3'd2:    oe_q  <= 1'b1;
            default: scl_q <= 1'b0;
          endcase
          if (sub_q == 3'd3) begin
            phase_q <= PH_ADDR;
            sub_q   <= '0;
            bit_q   <= BIT_W'(ABYTE_W - 1);
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        PH_ADDR: begin
          case (sub_q)
            3'd0:    oe_q  <= !addr_byte[bit_q];
            3'd1:    scl_q <= 1'b1;
            default: scl_q <= 1'b0;
          endcase
          if (sub_q == 3'd2) begin
            sub_q <= '0;
            if (bit_q == '0) phase_q <= PH_AACK;
            else             bit_q   <= bit_q - 1'b1;
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        PH_AACK, PH_DACK: begin
          case (sub_q)
            3'd0:    oe_q  <= 1'b0;
            3'd1:    scl_q <= 1'b1;
            3'd2:    ack_q <= sda_s;
            3'd3:    scl_q <= 1'b0;
            default: oe_q  <= 1'b0;
          endcase
          if (sub_q == 3'd4) begin
            sub_q <= '0;
            if (phase_q == PH_AACK && !ack_q) begin
              phase_q <= PH_DATA;
              bit_q   <= BIT_W'(DATA_W - 1);
            end else if (last_word) begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_START;
              word_q  <= word_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        PH_DATA: begin
          case (sub_q)
            3'd0:    oe_q    <= 1'b0;
            3'd1:    scl_q   <= 1'b1;
            3'd2:    shreg_q <= {shreg_q[DATA_W-2:0], sda_s};
            3'd3:    scl_q   <= 1'b0;
            default: oe_q    <= 1'b1;
          endcase
          if (sub_q == 3'd4) begin
            sub_q <= '0;
            if (bit_q == '0) phase_q <= PH_DACK;
            else             bit_q   <= bit_q - 1'b1;
          end else begin
            sub_q <= sub_q + 3'd1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign scl_o    = scl_q;
  assign sda_oe_o = oe_q;

  // Spacing monitor for line changes
  logic          scl_d, oe_d;
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      oe_d  <= 1'b0;
      gap_q <= GW'(HOLD_CYC);
    end else begin
      scl_d <= scl_q;
      oe_d  <= oe_q;
      if (scl_q != scl_d || oe_q != oe_d) gap_q <= '0;
      else if (gap_q != GW'(HOLD_CYC))    gap_q <= gap_q + 1'b1;
    end

  // R7
  line_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(scl_o) || !$stable(sda_oe_o)) |-> (32'(gap_q) >= HOLD_CYC - 1));

  // R3
  no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && scl_o && $past(scl_o)) |-> !$fell(sda_oe_o));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  // R8
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (word_q >= $past(word_q)));
endmodule

// File: tb/sim_rom_snapshot.sv
module sim_rom_snapshot;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 4;
  localparam int MAX_WAIT   = 60000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       busy, done, scl, oe;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       slave_pull = 1'b0;
  wire        sda_line = !(oe || slave_pull);

  int checks = 0;
  int errors = 0;
  int run_id = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_snapshot #(.HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .scl_o(scl), .sda_oe_o(oe), .sda_i(sda_line),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [7:0] content(input int w, input int r);
    logic [7:0] v;
    v = 8'(w * 3 + 8'h17);
    return (r == 0) ? v : (v ^ 8'h5A);
  endfunction

  function automatic bit refused(input int w, input int r);
    if (r == 0) return (w == 0) || (w == 9) || (w == 127);
    return (w == 64);
  endfunction

  function automatic logic [7:0] expect_byte(input int w, input int r);
    return refused(w, r) ? 8'hFF : content(w, r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioral memory model
  typedef enum int {S_IDLE, S_ADDR, S_AACK, S_DATA} sst_t;
  sst_t       sst = S_IDLE;
  int         bcnt = 0, bidx = 0, cur_word = 0;
  logic [7:0] shreg = '0, dbyte = '0;
  int         n_start = 0, n_stop = 0, n_addr = 0, addr_bad = 0;

  always @(negedge sda_line) if (rst_n && scl === 1'b1) begin
    n_start++;
    sst = S_ADDR; bcnt = 0; shreg = '0; slave_pull = 1'b0;
  end
  always @(posedge sda_line) if (rst_n && busy && scl === 1'b1) n_stop++;

  always @(posedge scl) if (sst == S_ADDR) begin
    shreg = {shreg[6:0], sda_line};
    bcnt++;
  end

  always @(negedge scl) begin
    case (sst)
      S_ADDR: if (bcnt == 8) begin
        cur_word = int'(shreg[7:1]);
        if (shreg != {7'(n_addr), 1'b1}) addr_bad++;
        n_addr++;
        if (shreg[0] && !refused(cur_word, run_id)) begin
          slave_pull = 1'b1; sst = S_AACK;
        end else sst = S_IDLE;
      end
      S_AACK: begin
        dbyte = content(cur_word, run_id);
        bidx = 7; slave_pull = !dbyte[7]; sst = S_DATA;
      end
      S_DATA: if (bidx == 0) begin
        slave_pull = 1'b0; sst = S_IDLE;
      end else begin
        bidx--; slave_pull = !dbyte[bidx];
      end
      default: ;
    endcase
  end

  // Line-change spacing monitor (R7)
  logic pscl = 1'b1, poe = 1'b0;
  int   gap = 0, gap_bad = 0;
  bit   seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (scl !== pscl || oe !== poe) begin
      if (seen && gap < HOLD) gap_bad++;
      gap = 1; seen = 1;
    end else gap++;
    pscl = scl; poe = oe;
  end

  localparam logic [6:0] PROBE [0:11] = '{7'd0, 7'd1, 7'd8, 7'd9, 7'd10, 7'd31,
                                          7'd63, 7'd64, 7'd65, 7'd100, 7'd126, 7'd127};

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < MAX_WAIT) begin
      @(negedge clk); n++;
    end
    check(done === 1'b1, "R8 watchdog", n, MAX_WAIT);
  endtask

  task automatic sweep(input string req, input int r);
    int bad = 0;
    for (int w = 0; w < 128; w++) begin
      rd_addr = 7'(w); #1;
      if (rd_data !== expect_byte(w, r)) begin
        bad++;
        $display("FAIL %s word %0d: actual=%0h expected=%0h", req, w, rd_data, expect_byte(w, r));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && done === 1'b0, "R1 flags", {busy, done}, 0);
    check(scl === 1'b1 && oe === 1'b0, "R1 lines", {scl, oe}, 2);
    rst_n = 1'b1;
    @(negedge clk);

    // Run 0
    pulse_start();
    @(negedge clk);
    check(busy === 1'b1 && done === 1'b0, "R2 busy after start", {busy, done}, 2);
    repeat (2000) @(negedge clk);
    pulse_start();   // R8 ignored while busy
    wait_done();
    check(busy === 1'b0, "R8 busy low at end", busy, 0);
    check(n_start == 128, "R3 start count", n_start, 128);
    check(n_stop == 0, "R3 stop count", n_stop, 0);
    check(n_addr == 128 && addr_bad == 0, "R4 address sequence", addr_bad, 0);
    check(gap_bad == 0, "R7 line spacing", gap_bad, 0);

    // Probe table: R5 for acknowledged words, R6 for refused ones
    for (int i = 0; i < 12; i++) begin
      rd_addr = PROBE[i]; #1;
      check(rd_data === expect_byte(int'(PROBE[i]), 0),
            refused(int'(PROBE[i]), 0) ? "R6 refused word" : "R5 data word",
            rd_data, expect_byte(int'(PROBE[i]), 0));
    end
    sweep("R5/R6 sweep run0", 0);
    repeat (20) @(negedge clk);
    check(done === 1'b1, "R8 done holds", done, 1);

    // Run 1: new contents, different refused word (R9)
    run_id = 1; n_start = 0; n_stop = 0; n_addr = 0; addr_bad = 0;
    pulse_start();
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b1, "R2 done cleared", {busy, done}, 2);
    wait_done();
    check(n_start == 128 && n_addr == 128 && addr_bad == 0, "R4 run1 sequence", addr_bad, 0);
    rd_addr = 7'd0; #1;
    check(rd_data === content(0, 1), "R9 word0 overwritten", rd_data, content(0, 1));
    rd_addr = 7'd127; #1;
    check(rd_data === content(127, 1), "R9 word127 overwritten", rd_data, content(127, 1));
    rd_addr = 7'd64; #1;
    check(rd_data === 8'hFF, "R6 run1 refused", rd_data, 8'hFF);
    sweep("R9 sweep run1", 1);
    check(gap_bad == 0, "R7 spacing run1", gap_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule